// File: doc/BRIEF.md
# Byte-latched program counter

This block holds the fetch address of an 8-bit processor core. The address is 21 bits wide and counts bytes. It is kept as three byte fields: a low byte (bits 7:0), a high byte (bits 15:8) and an upper field (bits 20:16). The core's data bus reaches only the low byte, which it can read and write. The high and upper fields cannot be reached directly. Software changes them by writing two holding latches, which take effect the next time the low byte is written. Reading the low byte copies the current high and upper fields back into those latches. This lets software compute an offset into a table and jump to it.

Instruction-driven flow bypasses the latches. A jump, branch or call loads all 21 bits from a target input. A return loads all 21 bits from the return-stack pop port. A sequential advance adds two. Bit 0 always reads as zero, so every fetch stays on an instruction-word boundary.

Top module: `pc_byte_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, both holding latches and the read-edge detector clear to zero. After reset, a low-byte write of 0x55 gives the address 0x000054.
- R2: An advance (`step_i`) with no higher-priority request adds 2 to the address, modulo 2^21. From 0x1FFFFE it wraps to 0x000000.
- R3: A low-byte write (`lo_wr_i`) with no load request sets the address to {upper latch, high latch, `bus_wdata_i[7:1]`, 0}. The latch values used are those held before that edge.
- R4: Bit 0 of `fetch_addr_o` is 0 at all times. A load target or bus write data with bit 0 set still yields bit 0 equal to 0.
- R5: A direct load (`jump_i`) sets the address to `jump_tgt_i` with bit 0 cleared. It ignores both holding latches and leaves them unchanged.
- R6: A pop load (`pop_i`) sets the address to `pop_tgt_i` with bit 0 cleared and leaves the latches unchanged. When `jump_i` and `pop_i` arrive together, `jump_i` wins.
- R7: On the first cycle of a low-byte read (`lo_rd_i` high after a low cycle), the high latch takes address bits 15:8 and the upper latch takes bits 20:16. Both are taken as they were before the edge. If `lo_rd_i` stays high, no further copy happens.
- R8: A bus write to the high latch (`hi_wr_i`) loads `bus_wdata_i`. A bus write to the upper latch (`up_wr_i`) loads `bus_wdata_i[4:0]`. In a cycle where a read edge also occurs, the bus write wins for the latch it targets.
- R9: Requests are ranked from highest to lowest: direct or pop load, then low-byte write, then advance. A lower-ranked request in the same cycle has no effect on the address.
- R10: `lo_rdata_o` always equals bits 7:0 of the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Sequential advance by 2 |
| jump_i | input | 1 | Direct load (call, relative call, goto, branch) |
| jump_tgt_i | input | 21 | Direct load target |
| pop_i | input | 1 | Load from the return-stack pop port |
| pop_tgt_i | input | 21 | Popped return address |
| lo_wr_i | input | 1 | Data-bus write to the low byte |
| lo_rd_i | input | 1 | Data-bus read strobe for the low byte |
| hi_wr_i | input | 1 | Data-bus write to the high holding latch |
| up_wr_i | input | 1 | Data-bus write to the upper holding latch |
| bus_wdata_i | input | 8 | Data-bus write data |
| fetch_addr_o | output | 21 | Fetch address |
| lo_rdata_o | output | 8 | Low byte presented for a data-bus read |

## Verification
The collision of most interest is a low-byte write meeting a latch-changing event in the same cycle. That event can be a bus write to a holding latch or a rising read strobe. The write must use the latch contents from before the edge, and the latch must end up holding the new value. The bench provokes this in directed cycles: a read edge together with a high-latch write, and a low-byte write together with an upper-latch write. Random traffic also sets these strobes independently, so many more such cycles occur. A bench model updates the address and both latches from the pre-edge values and compares the fetch address after every edge. The latch contents become visible at the ports whenever a later low-byte write moves them into the address.

// File: rtl/pcl_pkg.sv
// Package: shared selection encoding for the byte-latched program counter.
// Assumes: consumers import it before declaring their ports.
package pcl_pkg;

    // Source of the next counter value, in rising priority order.
    typedef enum logic [1:0] {
        PCL_SEL_HOLD = 2'd0,
        PCL_SEL_STEP = 2'd1,
        PCL_SEL_LOWR = 2'd2,
        PCL_SEL_LOAD = 2'd3
    } pcl_sel_e;

    // Lowest address bit that the low byte does not cover.
    localparam int unsigned PCL_HI_LSB = 8;
    // Lowest address bit of the upper field.
    localparam int unsigned PCL_UP_LSB = 16;

endpackage

// File: rtl/pcl_hold_latch.sv
// Module: the two holding latches for the hidden high and upper address fields.
// Reading the low byte copies the live fields in, but only on the first cycle
// of a read strobe. A data-bus write to a latch beats that copy.
// Assumes: synchronous active-low reset, and a UP_W of at least 1.
module pcl_hold_latch #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned UP_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              hi_wr_i,
    input  logic              up_wr_i,
    input  logic [BYTE_W-1:0] hi_wdata_i,
    input  logic [UP_W-1:0]   up_wdata_i,
    input  logic [BYTE_W-1:0] pc_hi_i,
    input  logic [UP_W-1:0]   pc_up_i,
    output logic [BYTE_W-1:0] hold_hi_o,
    output logic [UP_W-1:0]   hold_up_o
);

    logic rd_q;
    logic rd_edge;

    // Purpose: remember last cycle's read strobe so that only its first cycle counts.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_i;
    end

    assign rd_edge = rd_i & ~rd_q;

    // Purpose: high latch takes the bus write first, otherwise a copy on a read edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_hi_o <= '0;
        else if (hi_wr_i) hold_hi_o <= hi_wdata_i;
        else if (rd_edge) hold_hi_o <= pc_hi_i;
    end

    // Purpose: upper latch follows the same rule as the high latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_up_o <= '0;
        else if (up_wr_i) hold_up_o <= up_wdata_i;
        else if (rd_edge) hold_up_o <= pc_up_i;
    end

endmodule

// File: rtl/pcl_next_sel.sv
// Module: priority selection of the next counter value.
// Order, highest first: direct load, pop load, low-byte write, advance.
// Bit 0 of every result is forced to zero.
// Assumes: pure combinational logic; the latch values are the pre-edge contents.
module pcl_next_sel
    import pcl_pkg::*;
#(
    parameter int unsigned PC_W   = 21,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned UP_W   = PC_W - 16
) (
    input  logic [PC_W-1:0]   pc_q_i,
    input  logic              step_i,
    input  logic              jump_i,
    input  logic [PC_W-1:0]   jump_tgt_i,
    input  logic              pop_i,
    input  logic [PC_W-1:0]   pop_tgt_i,
    input  logic              lo_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [BYTE_W-1:0] hold_hi_i,
    input  logic [UP_W-1:0]   hold_up_i,
    output logic [PC_W-1:0]   pc_d_o,
    output pcl_sel_e          sel_o
);

    localparam logic [PC_W-1:0] STEP_INC   = PC_W'(2);
    localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(1);

    logic [PC_W-1:0] load_val;
    logic [PC_W-1:0] raw_val;

    // Purpose: direct load wins over pop when both arrive.
    always_comb begin
        load_val = jump_i ? jump_tgt_i : pop_tgt_i;
    end

    // Purpose: rank the requests and form the unaligned next value.
    always_comb begin
        if (jump_i || pop_i) begin
            sel_o   = PCL_SEL_LOAD;
            raw_val = load_val;
        end else if (lo_wr_i) begin
            sel_o   = PCL_SEL_LOWR;
            raw_val = {hold_up_i, hold_hi_i, wdata_i};
        end else if (step_i) begin
            sel_o   = PCL_SEL_STEP;
            raw_val = pc_q_i + STEP_INC;
        end else begin
            sel_o   = PCL_SEL_HOLD;
            raw_val = pc_q_i;
        end
    end

    // Purpose: keep the address on a word boundary.
    always_comb begin
        pc_d_o = raw_val & ALIGN_MASK;
    end

endmodule

// File: rtl/pcl_count_reg.sv
// Module: the counter register, split into byte fields for the consumers.
// Updates only when a source is selected.
// Assumes: synchronous active-low reset to address zero.
module pcl_count_reg
    import pcl_pkg::*;
#(
    parameter int unsigned PC_W   = 21,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned UP_W   = PC_W - 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pcl_sel_e          sel_i,
    input  logic [PC_W-1:0]   pc_d_i,
    output logic [PC_W-1:0]   pc_q_o,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic [UP_W-1:0]   up_o
);

    // Purpose: hold the address and load it when any source is active.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pc_q_o <= '0;
        else if (sel_i != PCL_SEL_HOLD) pc_q_o <= pc_d_i;
    end

    // Purpose: expose the three byte fields.
    always_comb begin
        lo_o = pc_q_o[BYTE_W-1:0];
        hi_o = pc_q_o[PCL_UP_LSB-1:PCL_HI_LSB];
        up_o = pc_q_o[PC_W-1:PCL_UP_LSB];
    end

endmodule

// File: rtl/pc_byte_latch.sv
// Module: top of the byte-latched program counter.
// Assumes: ADDR_W is greater than 16 and BYTE_W is 8.
module pc_byte_latch
    import pcl_pkg::*;
#(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              jump_i,
    input  logic [ADDR_W-1:0] jump_tgt_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] pop_tgt_i,
    input  logic              lo_wr_i,
    input  logic              lo_rd_i,
    input  logic              hi_wr_i,
    input  logic              up_wr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [BYTE_W-1:0] lo_rdata_o
);

    localparam int unsigned UP_W = ADDR_W - PCL_UP_LSB;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic [BYTE_W-1:0] pc_lo;
    logic [BYTE_W-1:0] pc_hi;
    logic [UP_W-1:0]   pc_up;
    logic [BYTE_W-1:0] hold_hi;
    logic [UP_W-1:0]   hold_up;
    pcl_sel_e          sel;

    pcl_hold_latch #(.BYTE_W(BYTE_W), .UP_W(UP_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (lo_rd_i),
        .hi_wr_i    (hi_wr_i),
        .up_wr_i    (up_wr_i),
        .hi_wdata_i (bus_wdata_i),
        .up_wdata_i (bus_wdata_i[UP_W-1:0]),
        .pc_hi_i    (pc_hi),
        .pc_up_i    (pc_up),
        .hold_hi_o  (hold_hi),
        .hold_up_o  (hold_up)
    );

    pcl_next_sel #(.PC_W(ADDR_W), .BYTE_W(BYTE_W), .UP_W(UP_W)) u_sel (
        .pc_q_i     (pc_q),
        .step_i     (step_i),
        .jump_i     (jump_i),
        .jump_tgt_i (jump_tgt_i),
        .pop_i      (pop_i),
        .pop_tgt_i  (pop_tgt_i),
        .lo_wr_i    (lo_wr_i),
        .wdata_i    (bus_wdata_i),
        .hold_hi_i  (hold_hi),
        .hold_up_i  (hold_up),
        .pc_d_o     (pc_d),
        .sel_o      (sel)
    );

    pcl_count_reg #(.PC_W(ADDR_W), .BYTE_W(BYTE_W), .UP_W(UP_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .pc_d_i (pc_d),
        .pc_q_o (pc_q),
        .lo_o   (pc_lo),
        .hi_o   (pc_hi),
        .up_o   (pc_up)
    );

    // Purpose: drive the fetch address and the readable low byte.
    always_comb begin
        fetch_addr_o = pc_q;
        lo_rdata_o   = pc_lo;
    end

endmodule

// File: rtl/pc_byte_latch_chk.sv
// Module: assertion checker, bound into pc_byte_latch.
// Assumes: it sees the top ports plus the two holding latches.
module pc_byte_latch_chk #(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned UP_W   = ADDR_W - 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_i,
    input logic              jump_i,
    input logic [ADDR_W-1:0] jump_tgt_i,
    input logic              pop_i,
    input logic [ADDR_W-1:0] pop_tgt_i,
    input logic              lo_wr_i,
    input logic              lo_rd_i,
    input logic              hi_wr_i,
    input logic              up_wr_i,
    input logic [BYTE_W-1:0] bus_wdata_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic [BYTE_W-1:0] hold_hi,
    input logic [UP_W-1:0]   hold_up
);

    localparam logic [ADDR_W-1:0] MASK0 = ~ADDR_W'(1);

    // R4
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr_o[0] == 1'b0);

    // R2
    step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !jump_i && !pop_i && !lo_wr_i)
        |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(2));

    // R5
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i |=> fetch_addr_o == ($past(jump_tgt_i) & MASK0));

    // R6
    pop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !jump_i) |=> fetch_addr_o == ($past(pop_tgt_i) & MASK0));

    // R3
    lowr_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_i && !jump_i && !pop_i)
        |=> fetch_addr_o == {$past(hold_up), $past(hold_hi), $past(bus_wdata_i[BYTE_W-1:1]), 1'b0});

    // R7
    rd_copy_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lo_rd_i) && !hi_wr_i) |=> hold_hi == $past(fetch_addr_o[15:8]));

    // R7
    rd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lo_rd_i) && lo_rd_i && !hi_wr_i && !up_wr_i)
        |=> $stable(hold_hi) && $stable(hold_up));

    // R8
    hi_bus_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_i |=> hold_hi == $past(bus_wdata_i));

    // R5
    jump_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_i && !lo_rd_i && !hi_wr_i && !up_wr_i) |=> $stable(hold_hi) && $stable(hold_up));

endmodule

bind pc_byte_latch pc_byte_latch_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step_i),
    .jump_i       (jump_i),
    .jump_tgt_i   (jump_tgt_i),
    .pop_i        (pop_i),
    .pop_tgt_i    (pop_tgt_i),
    .lo_wr_i      (lo_wr_i),
    .lo_rd_i      (lo_rd_i),
    .hi_wr_i      (hi_wr_i),
    .up_wr_i      (up_wr_i),
    .bus_wdata_i  (bus_wdata_i),
    .fetch_addr_o (fetch_addr_o),
    .hold_hi      (hold_hi),
    .hold_up      (hold_up)
);

// File: tb/pc_byte_latch_bench.sv
module pc_byte_latch_bench;

    localparam int  CLK_P = 10;
    localparam int  AW    = 21;
    localparam int  NRAND = 3000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_i = 1'b0, jump_i = 1'b0, pop_i = 1'b0;
    logic          lo_wr_i = 1'b0, lo_rd_i = 1'b0, hi_wr_i = 1'b0, up_wr_i = 1'b0;
    logic [AW-1:0] jump_tgt_i = '0, pop_tgt_i = '0;
    logic [7:0]    bus_wdata_i = '0;
    logic [AW-1:0] fetch_addr_o;
    logic [7:0]    lo_rdata_o;

    int n_chk = 0;
    int n_fail = 0;

    // Bench reference state.
    logic [AW-1:0] m_pc = '0;
    logic [7:0]    m_hi = '0;
    logic [4:0]    m_up = '0;
    logic          m_rdq = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pc_byte_latch u_pc_byte_latch (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
        .jump_tgt_i(jump_tgt_i), .pop_i(pop_i), .pop_tgt_i(pop_tgt_i),
        .lo_wr_i(lo_wr_i), .lo_rd_i(lo_rd_i), .hi_wr_i(hi_wr_i), .up_wr_i(up_wr_i),
        .bus_wdata_i(bus_wdata_i), .fetch_addr_o(fetch_addr_o), .lo_rdata_o(lo_rdata_o)
    );

    function automatic logic [AW-1:0] f_next_pc(input logic [AW-1:0] pc,
            input logic [7:0] hi, input logic [4:0] up);
        logic [AW-1:0] r;
        if (jump_i)       r = jump_tgt_i;
        else if (pop_i)   r = pop_tgt_i;
        else if (lo_wr_i) r = {up, hi, bus_wdata_i};
        else if (step_i)  r = pc + 21'd2;
        else              r = pc;
        r[0] = 1'b0;
        return r;
    endfunction

    task automatic model_edge();
        logic edge_seen;
        logic [AW-1:0] old_pc;
        edge_seen = lo_rd_i & ~m_rdq;
        old_pc = m_pc;
        m_pc = f_next_pc(m_pc, m_hi, m_up);
        if (hi_wr_i) m_hi = bus_wdata_i;
        else if (edge_seen) m_hi = old_pc[15:8];
        if (up_wr_i) m_up = bus_wdata_i[4:0];
        else if (edge_seen) m_up = old_pc[20:16];
        m_rdq = lo_rd_i;
    endtask

    task automatic check(input string tag);
        n_chk++;
        if (fetch_addr_o !== m_pc) begin
            n_fail++;
            $display("FAIL %s fetch_addr actual=%06h expected=%06h", tag, fetch_addr_o, m_pc);
        end
        n_chk++;
        if (lo_rdata_o !== m_pc[7:0]) begin
            n_fail++;
            $display("FAIL R10 lo_rdata actual=%02h expected=%02h", lo_rdata_o, m_pc[7:0]);
        end
    endtask

    task automatic cyc(input logic st, input logic jp, input logic [AW-1:0] jt,
            input logic pp, input logic [AW-1:0] pt, input logic lw, input logic lr,
            input logic hw, input logic uw, input logic [7:0] wd, input string tag);
        @(negedge clk);
        step_i = st; jump_i = jp; jump_tgt_i = jt; pop_i = pp; pop_tgt_i = pt;
        lo_wr_i = lw; lo_rd_i = lr; hi_wr_i = hw; up_wr_i = uw; bus_wdata_i = wd;
        @(posedge clk);
        model_edge();
        #1;
        check(tag);
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1");
        // R1: latches cleared, so a low-byte write gives 0x000054
        cyc(0, 0, '0, 0, '0, 1, 0, 0, 0, 8'h55, "R1");
        // R4: target with bit 0 set
        cyc(0, 1, 21'h1FFFFF, 0, '0, 0, 0, 0, 0, 8'h00, "R4");
        // R2: wrap at top of the space
        cyc(1, 0, '0, 0, '0, 0, 0, 0, 0, 8'h00, "R2");
        cyc(1, 0, '0, 0, '0, 0, 0, 0, 0, 8'h00, "R2");
        // R6: jump beats pop, then pop alone
        cyc(0, 1, 21'h012345, 1, 21'h00ABCD, 0, 0, 0, 0, 8'h00, "R6");
        cyc(0, 0, '0, 1, 21'h00ABCD, 0, 0, 0, 0, 8'h00, "R6");
        // R5 / R9: load beats low-byte write and advance
        cyc(1, 1, 21'h1A3400, 0, '0, 1, 0, 0, 0, 8'hFF, "R9");
        // R7: read edge copies, then a held read across a jump does not
        cyc(0, 0, '0, 0, '0, 0, 1, 0, 0, 8'h00, "R7");
        cyc(0, 1, 21'h000D58, 0, '0, 0, 1, 0, 0, 8'h00, "R7");
        // R3 / R9: write beats advance, merges copied latches
        cyc(1, 0, '0, 0, '0, 1, 0, 0, 0, 8'h35, "R3");
        // R8: read edge together with high-latch write
        cyc(0, 0, '0, 0, '0, 0, 1, 1, 0, 8'h77, "R8");
        cyc(0, 0, '0, 0, '0, 1, 0, 0, 0, 8'h10, "R8");
        // R8: upper latch takes low 5 bits; low-byte write uses old latch
        cyc(0, 0, '0, 0, '0, 1, 0, 0, 1, 8'hE3, "R8");
        cyc(0, 0, '0, 0, '0, 1, 0, 0, 0, 8'h21, "R8");
        for (int i = 0; i < NRAND; i++) begin
            cyc($urandom_range(1, 0) == 1, $urandom_range(15, 0) == 0, AW'($urandom),
                $urandom_range(15, 0) == 0, AW'($urandom), $urandom_range(4, 0) == 0,
                $urandom_range(3, 0) == 0, $urandom_range(7, 0) == 0,
                $urandom_range(7, 0) == 0, 8'($urandom), "R9");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule